// File: doc/BRIEF.md
# Carry-Select Adder with Early Carry Selection

This block adds two unsigned WIDTH-bit operands and a carry-in, producing a WIDTH-bit sum and a carry-out. Each bit position first forms a propagate bit (the XOR of the operand bits) and a generate bit (their AND). Two ripple carry chains then run side by side over those words. One chain assumes the incoming carry is clear and the other assumes it is set.

The real carry-in then picks one of the two carry words, bit by bit, with an AND-OR per position. The selection happens before any sum bit exists. A single XOR row between the propagate word and the chosen carry word, shifted up by one with the carry-in entering at bit 0, yields the sum. The top bit of the chosen carry word is the carry-out.

The logic is purely combinational. An optional output register, selected by a parameter, gives a clean sampling point. When it is enabled it has an active-low asynchronous reset.

Top module: `csel_adder`

## Requirements
- R1: For every operand pair and carry-in, the WIDTH+1-bit value {cout, sum} equals a + b + cin.
- R2: With cin = 0 and operands that share no set bit, sum equals a XOR b and cout is 0.
- R3: When a + b is all ones and cin = 1, the carry runs through every position: sum is 0 and cout is 1.
- R4: cout is 1 exactly when a + b + cin is at least 2^WIDTH.
- R5: Sum bit 0 equals a[0] XOR b[0] XOR cin.
- R6: With REG_OUT = 1, sum and cout change only on the rising clock edge after the inputs change. With REG_OUT = 0 they follow the inputs without a clock.
- R7: While rst_n is low, the registered sum and cout are 0, and they clear at once when rst_n falls.
- R8: The adder is correct for every input combination at WIDTH = 4 with REG_OUT = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry-in; selects between the two carry words |
| sum | output | WIDTH | Sum word |
| cout | output | 1 | Carry-out |

## Verification
The bench targets full-length carry propagation, such as AAAA + 5555 + 1 and FFFF + 0001. A design that swaps the two carry chains, or that seeds the carry-set chain wrongly at bit 0, would give a sum off by one or a missing carry-out on these inputs. Vectors with disjoint operands and with the carry-in alone expose a shifted or misaligned carry word in the final XOR row, which shows up as a wrong low-order sum bit. The bench also sweeps every input at four bits and probes the register by reading the outputs just before an edge and by pulsing reset in the middle of the run. This catches a stray cycle of latency or a synchronous reset.

// File: rtl/csel_adder.sv
module csel_adder #(
  parameter int WIDTH   = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  logic [WIDTH-1:0] half_sum;
  logic [WIDTH-1:0] half_cry;
  logic [WIDTH-1:0] carry_lo;
  logic [WIDTH-1:0] carry_hi;
  logic [WIDTH-1:0] carry_sel;
  logic [WIDTH-1:0] sum_comb;
  logic             cout_comb;

  assign half_sum = a ^ b;
  assign half_cry = a & b;

  assign carry_lo[0] = half_cry[0];
  assign carry_hi[0] = half_cry[0] | half_sum[0];

  for (genvar i = 1; i < WIDTH; i++) begin : g_chain
    assign carry_lo[i] = half_cry[i] | (half_sum[i] & carry_lo[i-1]);
    assign carry_hi[i] = half_cry[i] | (half_sum[i] & carry_hi[i-1]);
  end

  // carry_lo implies carry_hi, so one AND-OR per bit selects
  assign carry_sel = carry_lo | ({WIDTH{cin}} & carry_hi);

  assign sum_comb  = half_sum ^ {carry_sel[WIDTH-2:0], cin};
  assign cout_comb = carry_sel[WIDTH-1];

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum  <= '0;
        cout <= 1'b0;
      end else begin
        sum  <= sum_comb;
        cout <= cout_comb;
      end
    end
  end else begin : g_comb
    assign sum  = sum_comb;
    assign cout = cout_comb;
  end

endmodule

// File: rtl/csel_adder_chk.sv
module csel_adder_chk #(
  parameter int WIDTH   = 16,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout,
  input logic [WIDTH-1:0] c_lo,
  input logic [WIDTH-1:0] c_hi,
  input logic [WIDTH-1:0] c_sel
);

  logic [WIDTH:0] ref_total;
  assign ref_total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

  AST_CHAIN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (c_lo & ~c_hi) == '0); // R1

  AST_SEL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !cin |-> c_sel == c_lo); // R1

  AST_SEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cin |-> c_sel == c_hi); // R3

  if (REG_OUT) begin : g_reg_chk
    AST_TOTAL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> {cout, sum} == $past(ref_total)); // R6

    AST_CARRY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> cout == $past(ref_total[WIDTH])); // R4

    AST_LSB_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> sum[0] == $past(a[0] ^ b[0] ^ cin)); // R5

    AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |-> (sum == '0 && !cout)); // R7
  end else begin : g_comb_chk
    AST_TOTAL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      {cout, sum} == ref_total); // R1

    AST_LSB_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      sum[0] == (a[0] ^ b[0] ^ cin)); // R5
  end

endmodule

bind csel_adder csel_adder_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .a     (a),
  .b     (b),
  .cin   (cin),
  .sum   (sum),
  .cout  (cout),
  .c_lo  (carry_lo),
  .c_hi  (carry_hi),
  .c_sel (carry_sel)
);

// File: tb/csel_adder_tb.sv
`timescale 1ns/1ps
module csel_adder_tb;

  localparam int W  = 16;
  localparam int WS = 4;
  localparam int NV = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  a = '0, b = '0;
  logic          cin = 1'b0;
  logic [W-1:0]  sum;
  logic          cout;
  logic [WS-1:0] sa = '0, sb = '0;
  logic          scin = 1'b0;
  logic [WS-1:0] ssum;
  logic          scout;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  csel_adder #(.WIDTH(W), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

  csel_adder #(.WIDTH(WS), .REG_OUT(1'b0)) u_dut_small (
    .clk(clk), .rst_n(rst_n), .a(sa), .b(sb), .cin(scin), .sum(ssum), .cout(scout));

  // tag per row: R1 R4 R1 R1 R3 R4 R2 R5 R2 R5
  localparam logic [W-1:0] TA [NV] = '{16'h0000, 16'hFFFF, 16'hFFFF, 16'h1234, 16'hAAAA,
                                       16'h8000, 16'h00FF, 16'h7FFF, 16'hFFFF, 16'h0001};
  localparam logic [W-1:0] TB [NV] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h4321, 16'h5555,
                                       16'h8000, 16'h0F00, 16'h0000, 16'h0000, 16'h0000};
  localparam logic         TC [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1,
                                       1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [W:0]   TE [NV] = '{17'h00000, 17'h10000, 17'h1FFFF, 17'h05555, 17'h10000,
                                       17'h10000, 17'h00FFF, 17'h08000, 17'h0FFFF, 17'h00002};
  localparam string        TT [NV] = '{"R1", "R4", "R1", "R1", "R3",
                                       "R4", "R2", "R5", "R2", "R5"};

  task automatic chk(input string tag, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vc);
    @(negedge clk);
    a = va; b = vb; cin = vc;
    @(negedge clk);
  endtask

  initial begin
    a = 16'h1357; b = 16'h2468; cin = 1'b1;
    #1;
    chk("R7 reset", {cout, sum}, '0);
    repeat (3) @(negedge clk);
    chk("R7 held", {cout, sum}, '0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(TA[i], TB[i], TC[i]);
      chk(TT[i], {cout, sum}, TE[i]);
    end

    for (int i = 0; i < 200; i++) begin
      logic [W-1:0] ra, rb;
      logic rc;
      ra = W'($urandom); rb = W'($urandom); rc = 1'($urandom);
      apply(ra, rb, rc);
      chk("R1 random", {cout, sum}, {1'b0, ra} + {1'b0, rb} + {{W{1'b0}}, rc});
    end

    apply(16'h0F0F, 16'hF0F0, 1'b0);
    chk("R2 disjoint", {cout, sum}, {1'b0, 16'hFFFF});
    apply(16'hFFFF, 16'h0000, 1'b1);
    chk("R3 ripple", {cout, sum}, 17'h10000);
    apply(16'h0000, 16'h0000, 1'b1);
    chk("R5 carry only", {cout, sum}, 17'h00001);

    // R6: new inputs must not appear before the next edge
    @(negedge clk);
    a = 16'h0003; b = 16'h0004; cin = 1'b0;
    #1;
    chk("R6 hold", {cout, sum}, 17'h00001);
    @(negedge clk);
    chk("R6 update", {cout, sum}, 17'h00007);

    // R7: asynchronous clear mid-run
    #1 rst_n = 1'b0;
    #0.5;
    chk("R7 async", {cout, sum}, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // R8: exhaustive at four bits, unregistered
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        for (int z = 0; z < 2; z++) begin
          sa = WS'(x); sb = WS'(y); scin = 1'(z);
          #0.1;
          chk("R8 exhaustive", (W+1)'({scout, ssum}), (W+1)'(x + y + z));
        end
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule